// File: doc/BRIEF.md
# SCL Clock Divider with Duty-Cycle Control

This block generates the serial clock timing for an I2C master from a fast source clock. A single packed control word sets the phase lengths. When its high-time field is zero the waveform is symmetric, which is the standard-mode setting. When that field is nonzero the low and high phases are timed separately. Fast and fast-plus settings use this to get a clock that is roughly one third high and two thirds low. Each phase is held for its divider value plus a fixed 3 source cycles. A full fast-mode period is therefore 1.5 times the divider plus 6 cycles.

The output is an open-drain style "pull SCL low" request. The block also gives single-cycle strobes at every SCL fall and rise, for the bit engine that shifts data. It watches the sampled bus line during the high phase. While a target holds SCL low, the high-phase count is frozen, so clock stretching extends the period rather than shortening the high time.

The reset value of the control word is computed from the source and SCL rate parameters. With the defaults (19.2 MHz source, 100 kHz SCL) this gives a divider of 93. Software-style loading goes through a write strobe and takes effect at the next phase boundary.

Top module: `scl_clk_gen`

## Requirements
- R1: After reset SCL is released (`scl_low_o`=0) and both strobes are 0. The control word equals the one computed from `SRC_HZ`/`SCL_HZ`: for rates up to 100 kHz the divider is (src/f)/2-3 and the high-time field is 0; above that the divider is ((src/f)-6)*2/3 and the high-time field is half of it.
- R2: Control word fields are: bits 7:0 the low-phase (full-speed) divider, bits 10:8 the high-speed divider, and bits 23:16 the high-time divider. A word is captured on the clock edge where `cfg_wr`=1.
- R3: With the high-time field 0, the low phase and the high phase each last divider+3 source cycles when SCL is not stretched.
- R4: With the high-time field nonzero, the low phase lasts divider+3 cycles and the high phase lasts high-time+3 cycles.
- R5: `scl_fall_stb` is 1 for exactly the first cycle of each low phase and at no other time.
- R6: `scl_rise_stb` is 1 for exactly the first cycle of each high phase that follows a low phase, and at no other time.
- R7: During the high phase the count advances only in cycles where `scl_in`=1. Each cycle with `scl_in`=0 lengthens the high phase by one cycle.
- R8: With `run`=0 and the block idle, SCL stays released. When `run` is seen high while idle, the next cycle begins a low phase. A low phase always runs to completion. `run`=0 is honoured only at the end of a high phase, which then returns to idle with no strobe.
- R9: A new control word takes effect at the next phase start. A phase already in progress keeps the length it began with.
- R10: The high-speed divider field (bits 10:8) has no effect on SCL timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Enables clock generation |
| cfg_wr | input | 1 | Capture strobe for `cfg_word` |
| cfg_word | input | 24 | Packed timing control word |
| scl_in | input | 1 | Sampled SCL bus level |
| scl_low_o | output | 1 | 1 requests SCL to be pulled low |
| scl_rise_stb | output | 1 | One-cycle pulse at SCL release |
| scl_fall_stb | output | 1 | One-cycle pulse at SCL pull-low |

## Verification
A wrong phase count or limit shows at `scl_low_o` as an SCL edge that is one or more cycles early or late. It also shows as a strobe in the wrong cycle. Either appears on the first phase boundary after the fault, so within one divider period. A stuck or mis-decoded phase state shows at once as a strobe without an SCL edge, or as an edge without its strobe. A mishandled stretch or late `run` shows as a phase that ends while the bus is held, or as an early return to idle. Each of these is visible on the boundary cycle itself.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

    localparam int DIV_W  = 8;
    localparam int HS_W   = 3;
    localparam int PAD_W  = 16 - DIV_W - HS_W;
    localparam int CTL_W  = 16 + DIV_W;
    localparam int CNT_W  = DIV_W + 1;
    localparam int PH_EXTRA = 3;
    localparam int STD_MAX_HZ = 100_000;

    typedef struct packed {
        logic [DIV_W-1:0] hi_div;
        logic [PAD_W-1:0] rsvd;
        logic [HS_W-1:0]  hs_div;
        logic [DIV_W-1:0] fs_div;
    } ctl_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    // Last count value of a phase lasting div + PH_EXTRA cycles.
    function automatic logic [CNT_W-1:0] phase_last(input logic [DIV_W-1:0] div);
        return CNT_W'(div) + CNT_W'(PH_EXTRA - 1);
    endfunction

    // Control word for a given source and SCL rate.
    function automatic ctl_t ctl_for_rate(input int src_hz, input int scl_hz);
        ctl_t w;
        int ratio;
        int fs;
        w = '0;
        ratio = src_hz / scl_hz;
        if (scl_hz <= STD_MAX_HZ) begin
            fs = ratio / 2 - PH_EXTRA;
            w.hi_div = '0;
        end else begin
            fs = (ratio - 2 * PH_EXTRA) * 2 / 3;
            w.hi_div = DIV_W'(fs / 2);
        end
        w.fs_div = DIV_W'(fs);
        w.hs_div = HS_W'(3);
        return w;
    endfunction

endpackage

// File: rtl/scl_cfg_reg.sv
module scl_cfg_reg
    import scl_div_pkg::*;
#(
    parameter ctl_t RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CTL_W-1:0] word,
    output ctl_t             ctl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= RST_VAL;
        end else if (wr) begin
            ctl_q <= ctl_t'(word);
        end
    end

    p_cfg_load_r2: assert property (@(posedge clk) disable iff (rst)
        wr |=> (ctl_q == ctl_t'($past(word))));

endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] start_last,
    input  logic          en,
    output logic          done
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_q;

    assign done = en && (cnt_q == last_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            last_q <= '0;
        end else if (start) begin
            cnt_q  <= '0;
            last_q <= start_last;
        end else if (en && !done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Count never runs past the limit captured at phase start (R7: frozen hold).
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= last_q);

    p_hold_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        (!en && !start) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/scl_clk_gen.sv
module scl_clk_gen
    import scl_div_pkg::*;
#(
    parameter int SRC_HZ = 19_200_000,
    parameter int SCL_HZ = 100_000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             cfg_wr,
    input  logic [CTL_W-1:0] cfg_word,
    input  logic             scl_in,
    output logic             scl_low_o,
    output logic             scl_rise_stb,
    output logic             scl_fall_stb
);

    localparam ctl_t RST_CTL = ctl_for_rate(SRC_HZ, SCL_HZ);

    ctl_t             ctl_q;
    phase_e           ph_q;
    phase_e           ph_n;
    logic             tmr_start;
    logic [CNT_W-1:0] tmr_last;
    logic [CNT_W-1:0] low_last;
    logic [CNT_W-1:0] high_last;
    logic             tmr_en;
    logic             tmr_done;
    logic             rise_q;
    logic             fall_q;

    scl_cfg_reg #(.RST_VAL(RST_CTL)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_wr),
        .word  (cfg_word),
        .ctl_q (ctl_q)
    );

    assign low_last  = phase_last(ctl_q.fs_div);
    assign high_last = phase_last((ctl_q.hi_div == '0) ? ctl_q.fs_div : ctl_q.hi_div);
    assign tmr_en    = (ph_q == PH_LOW) || ((ph_q == PH_HIGH) && scl_in);

    scl_phase_timer #(.CW(CNT_W)) u_tmr (
        .clk        (clk),
        .rst        (rst),
        .start      (tmr_start),
        .start_last (tmr_last),
        .en         (tmr_en),
        .done       (tmr_done)
    );

    always_comb begin
        ph_n      = ph_q;
        tmr_start = 1'b0;
        tmr_last  = low_last;
        unique case (ph_q)
            PH_IDLE: begin
                if (run) begin
                    ph_n      = PH_LOW;
                    tmr_start = 1'b1;
                end
            end
            PH_LOW: begin
                if (tmr_done) begin
                    ph_n      = PH_HIGH;
                    tmr_start = 1'b1;
                    tmr_last  = high_last;
                end
            end
            PH_HIGH: begin
                if (tmr_done) begin
                    if (run) begin
                        ph_n      = PH_LOW;
                        tmr_start = 1'b1;
                    end else begin
                        ph_n = PH_IDLE;
                    end
                end
            end
            default: ph_n = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            ph_q   <= ph_n;
            fall_q <= (ph_n == PH_LOW)  && (ph_q != PH_LOW);
            rise_q <= (ph_n == PH_HIGH) && (ph_q == PH_LOW);
        end
    end

    assign scl_low_o    = (ph_q == PH_LOW);
    assign scl_rise_stb = rise_q;
    assign scl_fall_stb = fall_q;

    p_fall_edge_r5: assert property (@(posedge clk) disable iff (rst)
        scl_fall_stb |-> (scl_low_o && !$past(scl_low_o)));

    p_rise_edge_r6: assert property (@(posedge clk) disable iff (rst)
        scl_rise_stb |-> (!scl_low_o && $past(scl_low_o)));

    p_stretch_hold_r7: assert property (@(posedge clk) disable iff (rst)
        ((ph_q == PH_HIGH) && !scl_in) |=> (ph_q == PH_HIGH));

    p_idle_start_r8: assert property (@(posedge clk) disable iff (rst)
        ((ph_q == PH_IDLE) && run) |=> (scl_low_o && scl_fall_stb));

    p_low_completes_r8: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_LOW) |=> (ph_q != PH_IDLE));

    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(scl_rise_stb && scl_fall_stb));

endmodule

// File: tb/tb_scl_clk_gen.sv
module tb_scl_clk_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [23:0] cfg_word = '0;
    logic        stretch = 1'b0;
    logic        scl_in;
    logic        scl_low_o;
    logic        scl_rise_stb;
    logic        scl_fall_stb;

    int vectors = 0;
    int fails = 0;
    bit fin = 1'b0;
    string cur_req = "R1";

    // reference model state
    int m_ph = 0;       // 0 idle, 1 low, 2 high
    int m_rem = 0;
    int m_fs = 0;
    int m_hi = 0;
    bit m_low = 0;
    bit m_rise = 0;
    bit m_fall = 0;

    always #4 clk = ~clk;

    assign scl_in = ~scl_low_o & ~stretch;

    scl_clk_gen dut (
        .clk          (clk),
        .rst          (rst),
        .run          (run),
        .cfg_wr       (cfg_wr),
        .cfg_word     (cfg_word),
        .scl_in       (scl_in),
        .scl_low_o    (scl_low_o),
        .scl_rise_stb (scl_rise_stb),
        .scl_fall_stb (scl_fall_stb)
    );

    function automatic int low_len();
        return m_fs + 3;
    endfunction

    function automatic int high_len();
        return (m_hi == 0) ? m_fs + 3 : m_hi + 3;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_rem = 0; m_rise = 0; m_fall = 0;
            m_fs = (19_200_000 / 100_000) / 2 - 3;
            m_hi = 0;
        end else begin
            m_rise = 0; m_fall = 0;
            if (m_ph == 0) begin
                if (run) begin m_ph = 1; m_rem = low_len(); m_fall = 1; end
            end else if (m_ph == 1) begin
                m_rem = m_rem - 1;
                if (m_rem == 0) begin m_ph = 2; m_rem = high_len(); m_rise = 1; end
            end else begin
                if (scl_in) m_rem = m_rem - 1;
                if (m_rem == 0) begin
                    if (run) begin m_ph = 1; m_rem = low_len(); m_fall = 1; end
                    else m_ph = 0;
                end
            end
            if (cfg_wr) begin
                m_fs = int'(cfg_word[7:0]);
                m_hi = int'(cfg_word[23:16]);
            end
        end
        m_low = (m_ph == 1);
    end

    task automatic cmp(input string req, input string what, input bit act, input bit exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !fin) begin
            cmp(cur_req, "scl_low_o", scl_low_o, m_low);
            cmp("R6", "scl_rise_stb", scl_rise_stb, m_rise);
            cmp("R5", "scl_fall_stb", scl_fall_stb, m_fall);
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic load(input logic [7:0] fs, input logic [2:0] hs, input logic [7:0] hi);
        cfg_word = {hi, 5'b0, hs, fs};
        cfg_wr = 1'b1;
        cycles(1);
        cfg_wr = 1'b0;
    endtask

    task automatic wait_high();
        while (m_ph != 2) cycles(1);
    endtask

    initial begin
        cycles(3);
        rst = 1'b0;
        // R1: reset state, released and quiet
        cur_req = "R1";
        cycles(4);
        // R8: idle stays released with run low
        cur_req = "R8";
        cycles(6);
        // R1: default word timing (divider 93)
        cur_req = "R1";
        run = 1'b1;
        cycles(400);
        // R2 / R3: symmetric word, loaded while running (R9 boundary)
        cur_req = "R3";
        load(8'd5, 3'd3, 8'd0);
        cycles(250);
        // R4: asymmetric duty, applied at next phase (R9)
        cur_req = "R4";
        load(8'd8, 3'd3, 8'd4);
        cycles(80);
        cur_req = "R9";
        cycles(3);
        load(8'd2, 3'd3, 8'd1);
        cycles(60);
        // R10: high-speed field varied, timing unchanged
        cur_req = "R10";
        load(8'd2, 3'd7, 8'd1);
        cycles(40);
        load(8'd2, 3'd0, 8'd1);
        cycles(40);
        // R7: stretch during high phase
        cur_req = "R7";
        load(8'd6, 3'd3, 8'd3);
        cycles(30);
        wait_high();
        stretch = 1'b1;
        cycles(7);
        stretch = 1'b0;
        cycles(30);
        wait_high();
        cycles(1);
        stretch = 1'b1;
        cycles(12);
        stretch = 1'b0;
        cycles(30);
        // R8: run dropped during low phase; low completes, returns idle after high
        cur_req = "R8";
        while (m_ph != 1) cycles(1);
        run = 1'b0;
        cycles(40);
        run = 1'b1;
        cycles(25);
        wait_high();
        run = 1'b0;
        cycles(20);
        // R2: fast-mode style word for 400 kHz from 19.2 MHz
        cur_req = "R2";
        run = 1'b1;
        load(8'd28, 3'd3, 8'd14);
        cycles(200);
        run = 1'b0;
        cycles(60);
        fin = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            fin = 1'b1;
            fails++;
            $display("FAIL watchdog run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule